// File: doc/BRIEF.md
# Priority Context Set Prefetcher

This block sits beside a small fully associative cache of context model sets in an entropy decoder. It holds its own shadow copy of which set sits in each cache line and a least-recently-used order for those lines. Every cycle the decoder control logic offers up to two candidate set indices, ranked by priority. The block decides whether one of them should be loaded from backing memory, and which line it should overwrite. It can also tell the cache to mark a resident first candidate as most recently used. This keeps the fill of the second candidate from pushing the first one out.

Only one fill is in flight at a time. The memory side closes each fill with a one-cycle done pulse, and the shadow tags take the new set at that moment. A demand miss from the decoder takes the place of any prefetch in the cycle it is raised. When the cache is configured with a single line, the policy is narrower: only the first candidate counts, and it is loaded only when the decoder has no set in use or has released the one it holds.

Top module: `ctxset_prefetch`

## Requirements
- R1: After reset no line holds a set, and `fill_req` and `touch_req` are low.
- R2: When the first candidate is valid and absent, the block raises `fill_req` for one cycle with `fill_set` equal to that candidate. This happens in the cycle after the inputs are presented. `fill_line` names the victim line, numbered from 0.
- R3: While a fill is outstanding, no new `fill_req` is raised. The fill ends on the first `fill_done` pulse after the request, and that set becomes resident in `fill_line`. A `fill_done` pulse with no fill outstanding has no effect.
- R4: A set that is resident, or that is being filled, is never requested again.
- R5: The second candidate is requested only when the first candidate is valid and resident. If the first candidate is invalid, nothing is requested.
- R6: In multi-line mode, a first candidate that is resident but not most recently used raises `touch_req` with `touch_line` set to its line, one cycle after the inputs. That line becomes most recently used. A fill of the second candidate in the same cycle never picks the touched line as victim.
- R7: The victim is the least recently filled or touched line among the active lines. After reset, lines are used from the highest active index downward (with 4 lines: 3, 2, 1, 0, then 3 again).
- R8: In single-line mode (`active_lines` = 1), the second candidate is ignored, `touch_req` stays low, and every fill uses line 0.
- R9: In single-line mode, the first candidate is requested only when `set_busy` is low or `set_release` is high.
- R10: When `dmd_vld` is high, both candidates are ignored in that cycle. `dmd_set` is requested if it is absent, in every mode and regardless of `set_busy`.
- R11: `active_lines` gives the number of lines in use, counted from line 0. A value of 0 acts as 1, and a value above the line count acts as the line count. No fill ever names a line at or above that number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| active_lines | input | CNT_W | Number of cache lines in use (1 selects single-line mode) |
| cand0_vld | input | 1 | First (higher priority) candidate valid |
| cand0_set | input | SET_W | First candidate set index |
| cand1_vld | input | 1 | Second candidate valid |
| cand1_set | input | SET_W | Second candidate set index |
| set_busy | input | 1 | The decoder is using a set (single-line mode) |
| set_release | input | 1 | The set in use is no longer needed (single-line mode) |
| dmd_vld | input | 1 | Demand miss from the decoder |
| dmd_set | input | SET_W | Set index of the demand miss |
| fill_req | output | 1 | One-cycle fill request to backing memory |
| fill_set | output | SET_W | Set index to load |
| fill_line | output | LINE_W | Cache line to overwrite |
| fill_done | input | 1 | Backing memory has finished the outstanding fill |
| touch_req | output | 1 | Ask the cache to make a line most recently used |
| touch_line | output | LINE_W | Line to refresh |

## Verification
The assertions watch properties that hold on every cycle. A request is never followed directly by another. A completed fill never duplicates a set that another line already holds. The recency order always has exactly one newest line and always yields a victim. No line is refreshed in single-line mode, and a refresh never targets the line being filled in the same cycle. Other behaviours depend on history, and only the directed scenarios can show them: the order in which victims are chosen, the choice between the first and second candidate, the single-line gating on the decoder's set usage, and demand misses taking over a cycle.

// File: rtl/ctxpf_pkg.sv
package ctxpf_pkg;

  // Source of the fill decided in the current cycle.
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_DEMAND = 2'd1,
    SRC_FIRST  = 2'd2,
    SRC_SECOND = 2'd3
  } fill_src_e;

  localparam int unsigned NKEY = 3;  // cand0, cand1, demand

endpackage

// File: rtl/ctxpf_tags.sv
module ctxpf_tags #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned SET_W     = 6,
  parameter int unsigned LINE_W    = 2,
  parameter int unsigned NKEY      = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_LINES-1:0]           active_mask,
  input  logic                           wr_en,
  input  logic [LINE_W-1:0]              wr_line,
  input  logic [SET_W-1:0]               wr_set,
  input  logic [NKEY-1:0][SET_W-1:0]     key_set,
  output logic [NKEY-1:0]                key_hit,
  output logic [LINE_W-1:0]              key0_line
);

  logic [NUM_LINES-1:0][SET_W-1:0] tag_q, tag_d;
  logic [NUM_LINES-1:0]            vld_q, vld_d;

  // next state
  always_comb begin
    tag_d = tag_q;
    vld_d = vld_q;
    if (wr_en) begin
      tag_d[wr_line] = wr_set;
      vld_d[wr_line] = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      vld_q <= '0;
    end else if (wr_en) begin
      tag_q <= tag_d;
      vld_q <= vld_d;
    end
  end

  // lookup per key
  for (genvar k = 0; k < NKEY; k++) begin : g_key
    always_comb begin
      key_hit[k] = 1'b0;
      for (int i = 0; i < NUM_LINES; i++) begin
        if (vld_q[i] && active_mask[i] && tag_q[i] == key_set[k])
          key_hit[k] = 1'b1;
      end
    end
  end

  always_comb begin
    key0_line = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (vld_q[i] && active_mask[i] && tag_q[i] == key_set[0])
        key0_line = LINE_W'(i);
    end
  end

  // a completing fill must not duplicate a set held in another line
  logic dup_other;
  always_comb begin
    dup_other = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (LINE_W'(i) != wr_line && vld_q[i] && tag_q[i] == wr_set)
        dup_other = 1'b1;
    end
  end

  assert_no_duplicate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !dup_other);

endmodule

// File: rtl/ctxpf_lru.sv
module ctxpf_lru #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned LINE_W    = 2,
  parameter int unsigned CNT_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     active_cnt,
  input  logic                 touch_en,
  input  logic [LINE_W-1:0]    touch_ln,
  input  logic                 done_en,
  input  logic [LINE_W-1:0]    done_ln,
  output logic [NUM_LINES-1:0] is_mru,
  output logic [LINE_W-1:0]    victim_ln,
  output logic                 victim_ok
);

  logic [NUM_LINES-1:0][LINE_W-1:0] age_q, age_d;
  logic                             upd_en;
  logic [LINE_W-1:0]                upd_ln;
  logic [CNT_W-1:0]                 last_age;
  logic [CNT_W-1:0]                 tgt_age;

  assign upd_en = touch_en | done_en;
  assign upd_ln = touch_en ? touch_ln : done_ln;

  // next state: moved line becomes age 0, younger lines age by one
  always_comb begin
    age_d = age_q;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (LINE_W'(i) == upd_ln)
        age_d[i] = '0;
      else if (age_q[i] < age_q[upd_ln])
        age_d[i] = age_q[i] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) age_q[i] <= LINE_W'(i);
    end else if (upd_en) begin
      age_q <= age_d;
    end
  end

  // victim seen after a same-cycle touch
  always_comb begin
    last_age = active_cnt - 1'b1;
    tgt_age  = last_age;
    if (touch_en && active_cnt > CNT_W'(1) &&
        CNT_W'(age_q[touch_ln]) == last_age)
      tgt_age = last_age - 1'b1;
  end

  always_comb begin
    victim_ln = '0;
    victim_ok = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      is_mru[i] = (age_q[i] == '0);
      if (CNT_W'(i) < active_cnt && CNT_W'(age_q[i]) == tgt_age) begin
        victim_ln = LINE_W'(i);
        victim_ok = 1'b1;
      end
    end
  end

  assert_single_mru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_mru) == 1);

  assert_victim_found_R7: assert property (@(posedge clk) disable iff (!rst_n)
    victim_ok);

  assert_one_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(touch_en && done_en));

endmodule

// File: rtl/ctxpf_arbiter.sv
module ctxpf_arbiter
  import ctxpf_pkg::*;
(
  input  logic      busy,
  input  logic      single,
  input  logic      dmd_vld,
  input  logic      dmd_res,
  input  logic      c0_vld,
  input  logic      c0_res,
  input  logic      c0_tag_hit,
  input  logic      c0_mru,
  input  logic      c1_vld,
  input  logic      c1_res,
  input  logic      set_busy,
  input  logic      set_release,
  output fill_src_e src,
  output logic      touch_dec
);

  always_comb begin
    src       = SRC_NONE;
    touch_dec = 1'b0;
    if (!busy) begin
      if (dmd_vld) begin
        if (!dmd_res) src = SRC_DEMAND;
      end else if (single) begin
        if (c0_vld && !c0_res && (!set_busy || set_release))
          src = SRC_FIRST;
      end else if (c0_vld) begin
        if (!c0_res) begin
          src = SRC_FIRST;
        end else begin
          if (c0_tag_hit && !c0_mru) touch_dec = 1'b1;
          if (c1_vld && !c1_res)     src = SRC_SECOND;
        end
      end
    end
  end

endmodule

// File: rtl/ctxset_prefetch.sv
module ctxset_prefetch
  import ctxpf_pkg::*;
#(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned SET_W     = 6,
  localparam int unsigned LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int unsigned CNT_W    = $clog2(NUM_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  active_lines,
  input  logic              cand0_vld,
  input  logic [SET_W-1:0]  cand0_set,
  input  logic              cand1_vld,
  input  logic [SET_W-1:0]  cand1_set,
  input  logic              set_busy,
  input  logic              set_release,
  input  logic              dmd_vld,
  input  logic [SET_W-1:0]  dmd_set,
  output logic              fill_req,
  output logic [SET_W-1:0]  fill_set,
  output logic [LINE_W-1:0] fill_line,
  input  logic              fill_done,
  output logic              touch_req,
  output logic [LINE_W-1:0] touch_line
);

  // configuration clamp
  logic [CNT_W-1:0]     act_cnt;
  logic [NUM_LINES-1:0] active_mask;
  logic                 single;

  always_comb begin
    if (active_lines == '0)                    act_cnt = CNT_W'(1);
    else if (active_lines > CNT_W'(NUM_LINES)) act_cnt = CNT_W'(NUM_LINES);
    else                                       act_cnt = active_lines;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_mask
    assign active_mask[i] = CNT_W'(i) < act_cnt;
  end

  assign single = (act_cnt == CNT_W'(1));

  // state
  logic              busy_q, busy_d;
  logic [SET_W-1:0]  pend_set_q, pend_set_d;
  logic [LINE_W-1:0] pend_ln_q, pend_ln_d;
  logic              fill_req_d, touch_req_d;
  logic [SET_W-1:0]  fill_set_d;
  logic [LINE_W-1:0] fill_line_d, touch_line_d;
  logic              done_acc;

  assign done_acc = busy_q & fill_done;

  // shadow tags
  logic [NKEY-1:0][SET_W-1:0] keys;
  logic [NKEY-1:0]            hits;
  logic [LINE_W-1:0]          c0_line;

  assign keys = {dmd_set, cand1_set, cand0_set};

  ctxpf_tags #(
    .NUM_LINES(NUM_LINES), .SET_W(SET_W), .LINE_W(LINE_W), .NKEY(NKEY)
  ) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_mask(active_mask),
    .wr_en      (done_acc),
    .wr_line    (pend_ln_q),
    .wr_set     (pend_set_q),
    .key_set    (keys),
    .key_hit    (hits),
    .key0_line  (c0_line)
  );

  // residency counts the set in flight
  logic c0_res, c1_res, dmd_res;
  assign c0_res  = hits[0] | (busy_q && pend_set_q == cand0_set);
  assign c1_res  = hits[1] | (busy_q && pend_set_q == cand1_set);
  assign dmd_res = hits[2] | (busy_q && pend_set_q == dmd_set);

  // recency order
  fill_src_e            src;
  logic                 touch_dec;
  logic [NUM_LINES-1:0] is_mru;
  logic [LINE_W-1:0]    victim_ln;
  logic                 victim_ok;

  ctxpf_lru #(
    .NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .CNT_W(CNT_W)
  ) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_cnt(act_cnt),
    .touch_en  (touch_dec),
    .touch_ln  (c0_line),
    .done_en   (done_acc),
    .done_ln   (pend_ln_q),
    .is_mru    (is_mru),
    .victim_ln (victim_ln),
    .victim_ok (victim_ok)
  );

  ctxpf_arbiter u_arb (
    .busy       (busy_q),
    .single     (single),
    .dmd_vld    (dmd_vld),
    .dmd_res    (dmd_res),
    .c0_vld     (cand0_vld),
    .c0_res     (c0_res),
    .c0_tag_hit (hits[0]),
    .c0_mru     (is_mru[c0_line]),
    .c1_vld     (cand1_vld),
    .c1_res     (c1_res),
    .set_busy   (set_busy),
    .set_release(set_release),
    .src        (src),
    .touch_dec  (touch_dec)
  );

  // next state
  always_comb begin
    busy_d       = busy_q;
    pend_set_d   = pend_set_q;
    pend_ln_d    = pend_ln_q;
    fill_req_d   = 1'b0;
    fill_set_d   = fill_set;
    fill_line_d  = fill_line;
    touch_req_d  = touch_dec;
    touch_line_d = touch_dec ? c0_line : touch_line;

    if (done_acc) busy_d = 1'b0;

    if (src != SRC_NONE) begin
      unique case (src)
        SRC_DEMAND: fill_set_d = dmd_set;
        SRC_FIRST:  fill_set_d = cand0_set;
        SRC_SECOND: fill_set_d = cand1_set;
        default:    fill_set_d = fill_set;
      endcase
      fill_req_d  = 1'b1;
      fill_line_d = victim_ln;
      busy_d      = 1'b1;
      pend_set_d  = fill_set_d;
      pend_ln_d   = victim_ln;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      pend_set_q <= '0;
      pend_ln_q  <= '0;
      fill_req   <= 1'b0;
      fill_set   <= '0;
      fill_line  <= '0;
      touch_req  <= 1'b0;
      touch_line <= '0;
    end else begin
      busy_q    <= busy_d;
      fill_req  <= fill_req_d;
      touch_req <= touch_req_d;
      if (fill_req_d) begin
        pend_set_q <= pend_set_d;
        pend_ln_q  <= pend_ln_d;
        fill_set   <= fill_set_d;
        fill_line  <= fill_line_d;
      end
      if (touch_req_d) touch_line <= touch_line_d;
    end
  end

  assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |=> !fill_req);

  assert_touch_spared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_req && fill_req) |-> (fill_line != touch_line));

  assert_no_touch_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    touch_req |-> ($past(act_cnt) != CNT_W'(1)));

  assert_line_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> (CNT_W'(fill_line) < $past(act_cnt)));

endmodule

// File: tb/ctxset_prefetch_test.sv
module ctxset_prefetch_test;

  localparam int NL    = 4;
  localparam int SW    = 6;
  localparam int LW    = 2;
  localparam int CW    = 3;

  logic          clk;
  logic          rst_n;
  logic [CW-1:0] active_lines;
  logic          cand0_vld, cand1_vld, set_busy, set_release, dmd_vld, fill_done;
  logic [SW-1:0] cand0_set, cand1_set, dmd_set;
  logic          fill_req, touch_req;
  logic [SW-1:0] fill_set;
  logic [LW-1:0] fill_line, touch_line;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  ctxset_prefetch #(.NUM_LINES(NL), .SET_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .active_lines(active_lines),
    .cand0_vld(cand0_vld), .cand0_set(cand0_set),
    .cand1_vld(cand1_vld), .cand1_set(cand1_set),
    .set_busy(set_busy), .set_release(set_release),
    .dmd_vld(dmd_vld), .dmd_set(dmd_set),
    .fill_req(fill_req), .fill_set(fill_set), .fill_line(fill_line),
    .fill_done(fill_done),
    .touch_req(touch_req), .touch_line(touch_line)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic clear_in;
    cand0_vld = 0; cand1_vld = 0; dmd_vld = 0; fill_done = 0;
    set_busy = 0; set_release = 0;
    cand0_set = '0; cand1_set = '0; dmd_set = '0;
  endtask

  task automatic reset_dut(input int lines);
    clear_in();
    active_lines = CW'(lines);
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tick();
  endtask

  task automatic complete;
    clear_in();
    fill_done = 1;
    tick();
    fill_done = 0;
  endtask

  task automatic fill_one(input int s, input int ln, input string req);
    cand0_vld = 1; cand0_set = SW'(s);
    tick();
    chk(req, fill_req, 1);
    chk(req, fill_set, s);
    chk(req, fill_line, ln);
    complete();
  endtask

  task automatic t_reset;
    reset_dut(4);
    chk("R1 fill_req", fill_req, 0);
    chk("R1 touch_req", touch_req, 0);
    tick();
    chk("R1 idle fill_req", fill_req, 0);
  endtask

  task automatic t_priority;
    reset_dut(4);
    cand0_vld = 1; cand0_set = 5; cand1_vld = 1; cand1_set = 6;
    tick();
    chk("R2 req", fill_req, 1);
    chk("R5 first wins", fill_set, 5);
    chk("R7 line", fill_line, 3);
    tick();
    chk("R3 pulse", fill_req, 0);
    tick();
    chk("R3 waiting", fill_req, 0);
    fill_done = 1;
    tick();
    chk("R3 done cycle", fill_req, 0);
    fill_done = 0;
    tick();
    chk("R4/R5 second after first", fill_req, 1);
    chk("R5 second set", fill_set, 6);
    chk("R7 second line", fill_line, 2);
    chk("R6 no touch of MRU", touch_req, 0);
    complete();
  endtask

  task automatic t_order;
    reset_dut(4);
    fill_one(10, 3, "R7 fill a");
    fill_one(11, 2, "R7 fill b");
    fill_one(12, 1, "R7 fill c");
    fill_one(13, 0, "R7 fill d");
    fill_one(14, 3, "R7 wrap");
  endtask

  task automatic t_touch;
    reset_dut(4);
    fill_one(10, 3, "R7 t fill a");
    fill_one(11, 2, "R7 t fill b");
    fill_one(12, 1, "R7 t fill c");
    fill_one(13, 0, "R7 t fill d");
    cand0_vld = 1; cand0_set = 10; cand1_vld = 1; cand1_set = 20;
    tick();
    chk("R6 touch", touch_req, 1);
    chk("R6 touch line", touch_line, 3);
    chk("R5 second fill", fill_req, 1);
    chk("R5 second set", fill_set, 20);
    chk("R6 victim spares touched", fill_line, 2);
    complete();
    cand0_vld = 1; cand0_set = 10;
    tick();
    chk("R6 refresh again", touch_req, 1);
    chk("R6 refresh line", touch_line, 3);
    chk("R6 no fill", fill_req, 0);
    tick();
    chk("R6 MRU no touch", touch_req, 0);
    cand0_vld = 0; cand1_vld = 1; cand1_set = 40;
    tick();
    chk("R5 no first", fill_req, 0);
    cand0_vld = 1; cand0_set = 10; cand1_vld = 1; cand1_set = 30;
    tick();
    chk("R5 second", fill_req, 1);
    chk("R5 second set 30", fill_set, 30);
    chk("R7 oldest line", fill_line, 1);
    chk("R6 no touch", touch_req, 0);
    complete();
  endtask

  task automatic t_demand;
    reset_dut(4);
    dmd_vld = 1; dmd_set = 9; cand0_vld = 1; cand0_set = 7;
    tick();
    chk("R10 demand req", fill_req, 1);
    chk("R10 demand set", fill_set, 9);
    chk("R10 demand line", fill_line, 3);
    complete();
    dmd_vld = 1; dmd_set = 9; cand0_vld = 1; cand0_set = 7;
    tick();
    chk("R10 preempt", fill_req, 0);
    dmd_vld = 0;
    tick();
    chk("R10 prefetch resumes", fill_set, 7);
    chk("R10 prefetch line", fill_line, 2);
    complete();
  endtask

  task automatic t_spurious;
    reset_dut(4);
    fill_done = 1;
    tick();
    fill_done = 0;
    chk("R3 spurious done req", fill_req, 0);
    chk("R3 spurious done touch", touch_req, 0);
    fill_one(5, 3, "R3 normal after spurious");
    fill_done = 1;
    tick();
    fill_done = 0;
    fill_one(6, 2, "R3 order kept");
  endtask

  task automatic t_single;
    reset_dut(1);
    set_busy = 1; cand0_vld = 1; cand0_set = 4;
    tick();
    chk("R9 blocked busy", fill_req, 0);
    set_release = 1;
    tick();
    chk("R9 released", fill_req, 1);
    chk("R8 set", fill_set, 4);
    chk("R8 line 0", fill_line, 0);
    complete();
    cand0_vld = 1; cand0_set = 4; cand1_vld = 1; cand1_set = 8;
    tick();
    chk("R8 second ignored", fill_req, 0);
    chk("R8 no touch", touch_req, 0);
    cand1_vld = 0; cand0_set = 6;
    tick();
    chk("R9 idle fill", fill_req, 1);
    chk("R8 idle set", fill_set, 6);
    chk("R8 idle line", fill_line, 0);
    complete();
    set_busy = 1; dmd_vld = 1; dmd_set = 7;
    tick();
    chk("R10 single demand", fill_req, 1);
    chk("R10 single demand set", fill_set, 7);
    complete();
  endtask

  task automatic t_two_lines;
    reset_dut(2);
    fill_one(1, 1, "R11 first line");
    fill_one(2, 0, "R11 second line");
    fill_one(3, 1, "R11 wrap");
    reset_dut(0);
    fill_one(4, 0, "R11 zero acts as one");
  endtask

  initial begin
    rst_n = 0;
    active_lines = '0;
    clear_in();
    t_reset();
    t_priority();
    t_order();
    t_touch();
    t_demand();
    t_spurious();
    t_single();
    t_two_lines();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule